// File: doc/BRIEF.md
# Command-Gated Serial Register Interface

This block is the device-side serial register interface of a two-input sigma-delta converter. A host reaches the converter's registers over a four-wire SPI link. Before any other access, the host must write a one-byte command. That byte sets four things: the register the next transfer targets, whether that transfer reads or writes, the active input channel, and whether the converter sits in standby. When the targeted register has shifted its full width, the interface waits for a new command byte again.

Six registers sit behind the command gate:

- the command register itself (8 bits);
- two 8-bit configuration registers: setup and clock;
- a read-only 16-bit conversion result;
- two 24-bit calibration words: offset and gain.

The converter core pushes each new result in through a strobe. This lowers an active-low ready flag. Completing a read of the result raises the flag again. The flag also shows as the top bit of the command register. All serial pins are brought into the single system clock through synchronisers. A synchronous active-high reset silences the whole interface while it is held.

The configuration values are driven as plain ports toward the converter core. The modulator, filter and calibration arithmetic sit elsewhere.

Top module: `cmd_serial_if`

## Requirements
- R1: After reset, drdy_n is 1, cfg_setup is 0x01, cfg_clock is 0x05, cal_offset is 0x800000, cal_gain is 0x500000, cfg_channel and cfg_standby are 0, miso is 0, and the interface waits for a command byte.
- R2: While rst is 1, serial traffic and conv_valid pulses change no register and drdy_n stays 1.
- R3: The command byte is sent MSB first with bit fields:
  - [7] must be 0, or the byte is discarded;
  - [6:4] is the register select: 0 command, 1 setup, 2 clock, 3 result, 4 offset, 5 gain;
  - [3] is 1 for a read;
  - [2] is standby;
  - [1] is reserved;
  - [0] is the channel.
  cfg_channel and cfg_standby take the fields of each accepted byte. A command write with select 0 needs no further transfer.
- R4: A write to setup or clock (8 bits) or to offset or gain (24 bits) is taken MSB first on rising sclk edges. The register updates after its last bit, and the interface then returns to waiting for a command.
- R5: A read shifts the register out on miso MSB first. Each bit is valid for the host to sample at the next rising sclk edge. The first bit is valid at the first rising edge after the command byte.
- R6: A conv_valid pulse while not in standby loads conv_data into the result register and drives drdy_n to 0. Completing a 16-bit read of the result drives drdy_n to 1.
- R7: The result register can be read any number of times. Each read returns the value held when its command byte completed, even if a new result arrives during the read.
- R8: Reading the command register (select 0, read) returns {drdy_n, select, read bit, standby, 0, channel} of the byte just accepted.
- R9: Writes to the result register and to selects 6 and 7 are ignored. Reads of selects 6 and 7 return 8 zero bits.
- R10: Raising cs_n abandons any partial byte or transfer and returns the interface to waiting for a command.
- R11: While cfg_standby is 1, conv_valid pulses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from host, idles high |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host, 0 when not reading |
| conv_valid | input | 1 | One-cycle strobe: new conversion result |
| conv_data | input | 16 | Conversion result from converter core |
| drdy_n | output | 1 | Active-low new-data flag |
| cfg_channel | output | 1 | Selected input channel |
| cfg_standby | output | 1 | Standby request to converter core |
| cfg_setup | output | 8 | Setup register value |
| cfg_clock | output | 8 | Clock register value |
| cal_offset | output | 24 | Offset calibration word |
| cal_gain | output | 24 | Gain calibration word |

## Verification
The assertions assume three things about the inputs:
- sclk, cs_n and mosi change slowly enough that each level survives the two-stage synchroniser, so no edge is lost;
- conv_valid is a single-cycle strobe;
- a new result and the completion of a result read do not fall in the same clock cycle.

The stimulus holds each sclk phase for four system clocks. It changes mosi only while sclk is low, and it leaves eight clocks of quiet around every cs_n change. Every conv_valid pulse is one cycle wide and is issued between serial transfers or after a command byte, never in the cycle a read completes.

// File: rtl/cmd_serial_pkg.sv
package cmd_serial_pkg;

    localparam int CMD_W = 8;

    localparam logic [2:0] SEL_CMD    = 3'd0;
    localparam logic [2:0] SEL_SETUP  = 3'd1;
    localparam logic [2:0] SEL_CLOCK  = 3'd2;
    localparam logic [2:0] SEL_RESULT = 3'd3;
    localparam logic [2:0] SEL_OFFSET = 3'd4;
    localparam logic [2:0] SEL_GAIN   = 3'd5;

    typedef enum logic {
        PH_CMD  = 1'b0,
        PH_XFER = 1'b1
    } phase_e;

    typedef struct packed {
        logic       rdy_flag;
        logic [2:0] sel;
        logic       rnw;
        logic       standby;
        logic       rsvd;
        logic       chan;
    } cmd_t;

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // transfer length of the register addressed by a select value
    function automatic int unsigned reg_bits(logic [2:0] sel, int unsigned cfg_w,
                                             int unsigned data_w, int unsigned cal_w);
        case (sel)
            SEL_RESULT:          return data_w;
            SEL_OFFSET, SEL_GAIN: return cal_w;
            default:             return cfg_w;
        endcase
    endfunction

endpackage

// File: rtl/cmd_serial_sync.sv
module cmd_serial_sync #(
    parameter int         WIDTH     = 1,
    parameter int         STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= RESET_VAL;
        end else begin
            pipe[0] <= d_in;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign d_out = pipe[STAGES-1];
endmodule

// File: rtl/cmd_serial_regs.sv
module cmd_serial_regs
    import cmd_serial_pkg::*;
#(
    parameter int CFG_W   = 8,
    parameter int DATA_W  = 16,
    parameter int CAL_W   = 24,
    parameter int SHIFT_W = 24
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [2:0]         wr_sel,
    input  logic [SHIFT_W-1:0] wr_data,
    input  logic [2:0]         rd_sel,
    output logic [SHIFT_W-1:0] rd_val,
    input  logic               rd_done,
    input  logic               conv_valid,
    input  logic [DATA_W-1:0]  conv_data,
    input  logic               standby,
    output logic               drdy_n,
    output logic [CFG_W-1:0]   cfg_setup,
    output logic [CFG_W-1:0]   cfg_clock,
    output logic [CAL_W-1:0]   cal_offset,
    output logic [CAL_W-1:0]   cal_gain
);
    localparam logic [CFG_W-1:0] SETUP_RST  = CFG_W'(8'h01);
    localparam logic [CFG_W-1:0] CLOCK_RST  = CFG_W'(8'h05);
    localparam logic [CAL_W-1:0] OFFSET_RST = CAL_W'(1) << (CAL_W - 1);
    localparam logic [CAL_W-1:0] GAIN_RST   = CAL_W'(5) << (CAL_W - 4);

    logic [DATA_W-1:0] result_q;
    logic              take_conv;

    assign take_conv = conv_valid && !standby;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_setup  <= SETUP_RST;
            cfg_clock  <= CLOCK_RST;
            cal_offset <= OFFSET_RST;
            cal_gain   <= GAIN_RST;
            result_q   <= '0;
            drdy_n     <= 1'b1;
        end else begin
            if (wr_en) begin
                case (wr_sel)
                    SEL_SETUP:  cfg_setup  <= wr_data[CFG_W-1:0];
                    SEL_CLOCK:  cfg_clock  <= wr_data[CFG_W-1:0];
                    SEL_OFFSET: cal_offset <= wr_data[CAL_W-1:0];
                    SEL_GAIN:   cal_gain   <= wr_data[CAL_W-1:0];
                    default: ;
                endcase
            end
            if (take_conv) begin
                result_q <= conv_data;
                drdy_n   <= 1'b0;
            end else if (rd_done) begin
                drdy_n   <= 1'b1;
            end
        end
    end

    always_comb begin
        case (rd_sel)
            SEL_SETUP:  rd_val = SHIFT_W'(cfg_setup);
            SEL_CLOCK:  rd_val = SHIFT_W'(cfg_clock);
            SEL_RESULT: rd_val = SHIFT_W'(result_q);
            SEL_OFFSET: rd_val = SHIFT_W'(cal_offset);
            SEL_GAIN:   rd_val = SHIFT_W'(cal_gain);
            default:    rd_val = '0;
        endcase
    end
endmodule

// File: rtl/cmd_serial_if.sv
module cmd_serial_if
    import cmd_serial_pkg::*;
#(
    parameter int CFG_W       = 8,
    parameter int DATA_W      = 16,
    parameter int CAL_W       = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              mosi,
    output logic              miso,
    input  logic              conv_valid,
    input  logic [DATA_W-1:0] conv_data,
    output logic              drdy_n,
    output logic              cfg_channel,
    output logic              cfg_standby,
    output logic [CFG_W-1:0]  cfg_setup,
    output logic [CFG_W-1:0]  cfg_clock,
    output logic [CAL_W-1:0]  cal_offset,
    output logic [CAL_W-1:0]  cal_gain
);
    localparam int SHIFT_W = int'(max3(CFG_W, DATA_W, CAL_W));
    localparam int CNT_W   = $clog2(SHIFT_W + 1);

    logic sclk_s, cs_n_s, mosi_s, sclk_d, sclk_rise;

    cmd_serial_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b110)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  ({sclk, cs_n, mosi}),
        .d_out ({sclk_s, cs_n_s, mosi_s})
    );

    always_ff @(posedge clk) begin
        if (rst) sclk_d <= 1'b1;
        else     sclk_d <= sclk_s;
    end
    assign sclk_rise = sclk_s && !sclk_d;

    phase_e             phase;
    logic [CNT_W-1:0]   bit_cnt, xfer_len, new_len;
    cmd_t               cmd_q, cmd_in;
    logic [SHIFT_W-1:0] rx_sr, rx_next, tx_sr, tx_load, load_val, rd_val;
    logic [CMD_W-1:0]   cmd_rd;
    logic               wr_en, rd_done;
    logic [2:0]         wr_sel;
    logic [SHIFT_W-1:0] wr_data;

    always_comb begin
        rx_next  = {rx_sr[SHIFT_W-2:0], mosi_s};
        cmd_in   = cmd_t'(rx_next[CMD_W-1:0]);
        new_len  = CNT_W'(reg_bits(cmd_in.sel, CFG_W, DATA_W, CAL_W));
        cmd_rd   = {drdy_n, cmd_in.sel, cmd_in.rnw, cmd_in.standby, 1'b0, cmd_in.chan};
        load_val = (cmd_in.sel == SEL_CMD) ? SHIFT_W'(cmd_rd) : rd_val;
        tx_load  = load_val << (CNT_W'(SHIFT_W) - new_len);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_CMD;
            bit_cnt  <= '0;
            xfer_len <= CNT_W'(CMD_W);
            cmd_q    <= '0;
            rx_sr    <= '0;
            tx_sr    <= '0;
            wr_en    <= 1'b0;
            wr_sel   <= SEL_CMD;
            wr_data  <= '0;
            rd_done  <= 1'b0;
        end else begin
            wr_en   <= 1'b0;
            rd_done <= 1'b0;
            if (cs_n_s) begin
                phase   <= PH_CMD;
                bit_cnt <= '0;
            end else if (sclk_rise) begin
                rx_sr <= rx_next;
                if (phase == PH_CMD) begin
                    if (bit_cnt == CNT_W'(CMD_W - 1)) begin
                        bit_cnt <= '0;
                        if (!cmd_in.rdy_flag) begin
                            cmd_q    <= cmd_in;
                            xfer_len <= new_len;
                            tx_sr    <= tx_load;
                            if (cmd_in.rnw || cmd_in.sel != SEL_CMD) phase <= PH_XFER;
                        end
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end else begin
                    tx_sr <= tx_sr << 1;
                    if (bit_cnt == xfer_len - 1'b1) begin
                        bit_cnt <= '0;
                        phase   <= PH_CMD;
                        if (!cmd_q.rnw) begin
                            wr_en   <= 1'b1;
                            wr_sel  <= cmd_q.sel;
                            wr_data <= rx_next;
                        end else if (cmd_q.sel == SEL_RESULT) begin
                            rd_done <= 1'b1;
                        end
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
            end
        end
    end

    cmd_serial_regs #(.CFG_W(CFG_W), .DATA_W(DATA_W), .CAL_W(CAL_W), .SHIFT_W(SHIFT_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .rd_sel     (cmd_in.sel),
        .rd_val     (rd_val),
        .rd_done    (rd_done),
        .conv_valid (conv_valid),
        .conv_data  (conv_data),
        .standby    (cmd_q.standby),
        .drdy_n     (drdy_n),
        .cfg_setup  (cfg_setup),
        .cfg_clock  (cfg_clock),
        .cal_offset (cal_offset),
        .cal_gain   (cal_gain)
    );

    assign cfg_channel = cmd_q.chan;
    assign cfg_standby = cmd_q.standby;
    assign miso = (!cs_n_s && phase == PH_XFER && cmd_q.rnw) ? tx_sr[SHIFT_W-1] : 1'b0;
endmodule

// File: rtl/cmd_serial_if_chk.sv
module cmd_serial_if_chk
    import cmd_serial_pkg::*;
#(
    parameter int CNT_W = 5,
    parameter int CFG_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             cs_n_s,
    input phase_e           phase,
    input logic [CNT_W-1:0] bit_cnt,
    input logic             conv_valid,
    input logic             cfg_standby,
    input logic             drdy_n,
    input logic [CFG_W-1:0] cfg_setup,
    input logic             wr_en,
    input logic             rd_done
);
    // R2
    rst_mutes_ready_chk: assert property (@(posedge clk) rst |=> drdy_n);

    // R6
    new_result_lowers_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (conv_valid && !cfg_standby) |=> !drdy_n);

    // R6
    ready_rises_only_on_read_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(drdy_n) |-> $past(rd_done));

    // R11
    standby_holds_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_standby && drdy_n) |=> drdy_n);

    // R4
    setup_changes_on_write_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg_setup) |-> $past(wr_en));

    // R10
    deselect_returns_to_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n_s |=> (phase == PH_CMD && bit_cnt == '0));
endmodule

bind cmd_serial_if cmd_serial_if_chk #(.CNT_W(CNT_W), .CFG_W(CFG_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cs_n_s      (cs_n_s),
    .phase       (phase),
    .bit_cnt     (bit_cnt),
    .conv_valid  (conv_valid),
    .cfg_standby (cfg_standby),
    .drdy_n      (drdy_n),
    .cfg_setup   (cfg_setup),
    .wr_en       (wr_en),
    .rd_done     (rd_done)
);

// File: tb/cmd_serial_if_test.sv
module cmd_serial_if_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst = 1'b1;
    logic sclk = 1'b1, cs_n = 1'b1, mosi = 1'b0;
    logic miso, conv_valid = 1'b0, drdy_n, cfg_channel, cfg_standby;
    logic [15:0] conv_data = '0;
    logic [7:0]  cfg_setup, cfg_clock;
    logic [23:0] cal_offset, cal_gain;

    int checks = 0, errors = 0;
    bit finished = 0;

    logic [7:0]  m_setup = 8'h01, m_clock = 8'h05;
    logic [23:0] m_off = 24'h800000, m_gain = 24'h500000;
    logic [15:0] m_data = '0;
    logic        m_drdy = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmd_serial_if uut (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
        .conv_valid(conv_valid), .conv_data(conv_data), .drdy_n(drdy_n),
        .cfg_channel(cfg_channel), .cfg_standby(cfg_standby), .cfg_setup(cfg_setup),
        .cfg_clock(cfg_clock), .cal_offset(cal_offset), .cal_gain(cal_gain)
    );

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int bits_of(input logic [2:0] sel);
        if (sel == 3'd3) return 16;
        if (sel == 3'd4 || sel == 3'd5) return 24;
        return 8;
    endfunction

    function automatic logic [23:0] exp_read(input logic [2:0] sel);
        case (sel)
            3'd1: return {16'b0, m_setup};
            3'd2: return {16'b0, m_clock};
            3'd3: return {8'b0, m_data};
            3'd4: return m_off;
            3'd5: return m_gain;
            default: return '0;
        endcase
    endfunction

    function automatic logic [7:0] cmd_byte(input logic [2:0] sel, input logic rnw,
                                            input logic stby, input logic chan);
        return {1'b0, sel, rnw, stby, 1'b0, chan};
    endfunction

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic spi_begin;
        @(negedge clk); cs_n = 1'b0; sclk = 1'b1;
        wait_clks(8);
    endtask

    task automatic spi_end;
        wait_clks(8); cs_n = 1'b1;
        wait_clks(8);
    endtask

    task automatic shift(input int n, input logic [23:0] out, output logic [23:0] in);
        in = '0;
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk); sclk = 1'b0; mosi = out[i];
            wait_clks(4);
            in[i] = miso; sclk = 1'b1;
            wait_clks(3);
        end
    endtask

    task automatic access(input logic [2:0] sel, input logic rnw, input logic stby,
                          input logic chan, input logic [23:0] wdata, output logic [23:0] rdata);
        logic [23:0] dummy;
        spi_begin;
        shift(8, {16'b0, cmd_byte(sel, rnw, stby, chan)}, dummy);
        rdata = '0;
        if (rnw || sel != 3'd0) shift(bits_of(sel), wdata, rdata);
        spi_end;
    endtask

    task automatic pulse_conv(input logic [15:0] v);
        @(negedge clk); conv_data = v; conv_valid = 1'b1;
        @(negedge clk); conv_valid = 1'b0;
        wait_clks(2);
    endtask

    task automatic model_write(input logic [2:0] sel, input logic [23:0] v);
        case (sel)
            3'd1: m_setup = v[7:0];
            3'd2: m_clock = v[7:0];
            3'd4: m_off = v;
            3'd5: m_gain = v;
            default: ;
        endcase
    endtask

    task automatic check_ports(input string req);
        check(req, {16'b0, cfg_setup}, {16'b0, m_setup});
        check(req, {16'b0, cfg_clock}, {16'b0, m_clock});
        check(req, cal_offset, m_off);
        check(req, cal_gain, m_gain);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [23:0] rd, dummy;
        logic [15:0] d1, d2;
        logic [2:0]  sel;
        logic        rnw;
        logic [23:0] v;
        void'($urandom(32'h5EED1234));

        wait_clks(5);
        // R2: traffic and conversion strobes while reset is held
        access(3'd1, 1'b0, 1'b0, 1'b1, 24'hAA, dummy);
        pulse_conv(16'hBEEF);
        check("R2 drdy_n", {23'b0, drdy_n}, 24'h1);
        check("R2 setup", {16'b0, cfg_setup}, 24'h01);
        check("R2 channel", {23'b0, cfg_channel}, 24'h0);
        @(negedge clk); rst = 1'b0;
        wait_clks(4);

        // R1: reset state
        check_ports("R1");
        check("R1 drdy_n", {23'b0, drdy_n}, 24'h1);
        check("R1 channel/standby", {22'b0, cfg_channel, cfg_standby}, 24'h0);
        check("R1 miso", {23'b0, miso}, 24'h0);

        // R4: directed writes, R5: readback
        access(3'd1, 1'b0, 1'b0, 1'b0, 24'h5A, dummy);     model_write(3'd1, 24'h5A);
        access(3'd2, 1'b0, 1'b0, 1'b0, 24'h96, dummy);     model_write(3'd2, 24'h96);
        access(3'd4, 1'b0, 1'b0, 1'b0, 24'h123456, dummy); model_write(3'd4, 24'h123456);
        access(3'd5, 1'b0, 1'b0, 1'b0, 24'hFEDCBA, dummy); model_write(3'd5, 24'hFEDCBA);
        check_ports("R4");
        for (int s = 1; s <= 5; s++) begin
            if (s == 3) continue;
            access(3'(s), 1'b1, 1'b0, 1'b0, 24'h0, rd);
            check("R5 readback", rd, exp_read(3'(s)));
        end

        // R3: channel field, discarded byte with bit 7 set
        access(3'd2, 1'b0, 1'b0, 1'b1, 24'h3C, dummy); model_write(3'd2, 24'h3C);
        check("R3 channel", {23'b0, cfg_channel}, 24'h1);
        spi_begin; shift(8, 24'h80, dummy); spi_end;
        check("R3 bit7 discarded", {23'b0, cfg_channel}, 24'h1);
        access(3'd1, 1'b1, 1'b0, 1'b0, 24'h0, rd);
        check("R3 command after discard", rd, exp_read(3'd1));
        check("R3 channel cleared", {23'b0, cfg_channel}, 24'h0);

        // R6 / R7: new result, repeated reads
        d1 = 16'hA5C3;
        pulse_conv(d1); m_data = d1; m_drdy = 1'b0;
        check("R6 drdy low", {23'b0, drdy_n}, 24'h0);
        access(3'd3, 1'b1, 1'b0, 1'b0, 24'h0, rd); m_drdy = 1'b1;
        check("R7 first read", rd, exp_read(3'd3));
        check("R6 drdy high after read", {23'b0, drdy_n}, 24'h1);
        access(3'd3, 1'b1, 1'b0, 1'b0, 24'h0, rd);
        check("R7 second read", rd, exp_read(3'd3));

        // R8: command register read shows ready flag
        pulse_conv(16'h1357); m_data = 16'h1357; m_drdy = 1'b0;
        access(3'd0, 1'b1, 1'b0, 1'b1, 24'h0, rd);
        check("R8 command read", rd, {16'b0, m_drdy, 3'd0, 1'b1, 1'b0, 1'b0, 1'b1});
        access(3'd3, 1'b1, 1'b0, 1'b0, 24'h0, rd); m_drdy = 1'b1;
        check("R6 read clears", rd, exp_read(3'd3));

        // R7: snapshot taken at end of command byte
        d1 = 16'h0F0F; d2 = 16'hF00D;
        pulse_conv(d1); m_data = d1;
        spi_begin;
        shift(8, {16'b0, cmd_byte(3'd3, 1'b1, 1'b0, 1'b0)}, dummy);
        pulse_conv(d2);
        shift(16, 24'h0, rd);
        spi_end;
        check("R7 snapshot", rd, {8'b0, d1});
        m_data = d2; m_drdy = 1'b1;
        access(3'd3, 1'b1, 1'b0, 1'b0, 24'h0, rd);
        check("R7 newer result", rd, exp_read(3'd3));

        // R9: ignored writes, empty selects
        access(3'd3, 1'b0, 1'b0, 1'b0, 24'hFFFF, dummy);
        access(3'd6, 1'b0, 1'b0, 1'b0, 24'hFF, dummy);
        access(3'd3, 1'b1, 1'b0, 1'b0, 24'h0, rd);
        check("R9 result unchanged", rd, exp_read(3'd3));
        access(3'd7, 1'b1, 1'b0, 1'b0, 24'h0, rd);
        check("R9 select 7 reads zero", rd, 24'h0);
        check_ports("R9");

        // R10: abort mid-byte and mid-transfer
        spi_begin; shift(3, 24'h7, dummy); spi_end;
        spi_begin;
        shift(8, {16'b0, cmd_byte(3'd4, 1'b0, 1'b0, 1'b0)}, dummy);
        shift(10, 24'h3FF, dummy);
        spi_end;
        access(3'd1, 1'b0, 1'b0, 1'b0, 24'hC3, dummy); model_write(3'd1, 24'hC3);
        check("R10 write after abort", {16'b0, cfg_setup}, {16'b0, m_setup});
        check("R10 offset untouched", cal_offset, m_off);

        // R11: standby blocks conversion strobes
        access(3'd0, 1'b0, 1'b1, 1'b0, 24'h0, dummy);
        check("R11 standby set", {23'b0, cfg_standby}, 24'h1);
        pulse_conv(16'h7777);
        check("R11 drdy held", {23'b0, drdy_n}, 24'h1);
        access(3'd3, 1'b1, 1'b0, 1'b0, 24'h0, rd);
        check("R11 result unchanged", rd, exp_read(3'd3));

        // R4 / R5: constrained random accesses
        for (int k = 0; k < 40; k++) begin
            case ($urandom_range(3, 0))
                0: sel = 3'd1;
                1: sel = 3'd2;
                2: sel = 3'd4;
                default: sel = 3'd5;
            endcase
            rnw = 1'($urandom_range(1, 0));
            v = 24'($urandom);
            if (bits_of(sel) == 8) v = {16'b0, v[7:0]};
            access(sel, rnw, 1'b0, 1'($urandom_range(1, 0)), v, rd);
            if (rnw) check("R5 random read", rd, exp_read(sel));
            else begin
                model_write(sel, v);
                check_ports("R4 random write");
            end
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule